// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Burst Sequencing

This block is a synthesizable model of a small synchronous static RAM whose read and write commands can follow each other on every clock with no idle cycles between them. Every command, address, byte enable and write data word is sampled on the rising clock edge. A write's data word arrives a fixed number of cycles after its address, and that delay matches the read latency. A shared data bus can therefore carry read data and write data in adjacent cycles without a turnaround gap.

There are two read modes, chosen by a static input. In registered mode the read data passes through an output register and the write data trails its address by two cycles. In flow-through mode the read data is driven straight from the array and the write data trails its address by one cycle. Because the bus is bidirectional at chip level, the model has a separate data input, a data output and an output-drive qualifier.

Four-beat bursts are produced inside the block from one loaded address, in either linear or interleaved order. Three chip enables allow several instances to be stacked for more depth. An asynchronous output enable and an asynchronous sleep input complete the control set.

Top module: `lwsram`

## Requirements
- R1: A load cycle (`adv_ld`=0) starts a command only when `ce1`, `ce2` and `ce3` are all 1. The command is a write when `wr_en`=1 and a read when `wr_en`=0. A load cycle with any chip enable at 0 is a deselect: it writes nothing and returns no read data.
- R2: With `ft_mode`=0, a read whose address is sampled at edge k presents its word on `dout` with `dout_oe`=1 for the whole cycle between edge k+1 and edge k+2.
- R3: With `ft_mode`=1, a read whose address is sampled at edge k presents its word on `dout` with `dout_oe`=1 for the whole cycle between edge k and edge k+1.
- R4: The data word of a write is taken from `din` at edge k+2 when `ft_mode`=0, or at edge k+1 when `ft_mode`=1, where k is the edge at which its address was sampled. Byte lane i is `din[9i+8:9i]`. Lane i is written only if `byte_we[i]` was 1 at edge k; the other lanes keep their contents.
- R5: Reads and writes may be issued on consecutive edges in any mix. Every read returns the contents as left by all writes issued before it.
- R6: An advance cycle (`adv_ld`=1) repeats the previous read or write at the next burst address. Address bits above bit 1 are unchanged. For beat n, where n counts modulo 4, the low two bits are start+n modulo 4 when `burst_lin`=1 (sampled at the load), or start XOR n when `burst_lin`=0. An advance after a deselect, after sleep or after reset stays deselected.
- R7: With `ft_mode`=0, a read issued on the edge directly after a write to the same address returns that write's data in the lanes the write enabled. It returns the earlier contents in the other lanes.
- R8: `dout_oe` is 0 in any cycle in which `oe` is 0, with no clock edge needed.
- R9: While `sleep` is 1, `dout_oe` is 0 at once, and every command sampled is treated as a deselect. Array contents are retained and can be read back after `sleep` returns to 0.
- R10: After reset no command is pending and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| ft_mode | input | 1 | 1 = flow-through mode, 0 = registered mode; held static |
| addr | input | ADDR_W | Word address sampled on load cycles |
| adv_ld | input | 1 | 1 = advance the current burst, 0 = load a new command |
| wr_en | input | 1 | 1 = write, 0 = read, on load cycles |
| byte_we | input | NBYTE | Per-lane write enables, sampled with each write address |
| ce1 | input | 1 | Chip enable, active high |
| ce2 | input | 1 | Chip enable, active high |
| ce3 | input | 1 | Chip enable, active high |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down request |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Read data bus |
| dout_oe | output | 1 | High when `dout` carries valid read data and may be driven |

## Verification
The first pattern is a fill of the array by linear write bursts. After it comes a long random mix of loads, advances, deselects, byte masks and toggles of the output enable, run once in each mode, so that the two latencies are each checked against the same reference schedule. Directed sequences separate the less common cases. A write followed at once by a read of the same address tells forwarding from a stale array read. Bursts whose start offset is 1 tell linear order from interleaved. Partial chip-enable patterns and writes issued during sleep, each followed by a readback, show that those commands had no effect.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low address bits for a given beat of a four-beat burst.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
    if (linear) return start + beat;
    return start ^ beat;
  endfunction

endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
  import lwsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          adv_ld,
  input  logic          wr_en,
  input  logic          sel,
  input  logic          burst_lin,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byte_we,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [NB-1:0] s1_be,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NB-1:0] s2_be,
  output logic          load_go,
  output logic          cont_go
);
  localparam int OW = 2;

  op_e           last_op, cur_op;
  logic [AW-1:0] base_q, cur_addr;
  logic [OW-1:0] beat_q, beat_nx;
  logic          lin_q;

  always_comb begin
    load_go  = !sleep && !adv_ld && sel;
    cont_go  = !sleep && adv_ld && (last_op != OP_IDLE);
    beat_nx  = beat_q + 1'b1;
    cur_op   = OP_IDLE;
    cur_addr = addr;
    if (load_go) begin
      cur_op = wr_en ? OP_WR : OP_RD;
    end else if (cont_go) begin
      cur_op   = last_op;
      cur_addr = {base_q[AW-1:OW], beat_offset(base_q[OW-1:0], beat_nx, lin_q)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
      last_op <= OP_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
      lin_q   <= 1'b1;
    end else begin
      s1_op   <= cur_op;
      s1_addr <= cur_addr;
      s1_be   <= byte_we;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      if (load_go) begin
        last_op <= cur_op;
        base_q  <= addr;
        beat_q  <= '0;
        lin_q   <= burst_lin;
      end else if (cont_go) begin
        beat_q <= beat_nx;
      end else begin
        last_op <= OP_IDLE;
      end
    end
  end

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9,
  localparam int DW    = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NB-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane_mem[waddr] <= wdata[b*BW +: BW];
    end

    assign rdata[b*BW +: BW] = lane_mem[raddr];
  end

endmodule

// File: rtl/lwsram_rdpath.sv
module lwsram_rdpath
  import lwsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ft_mode,
  input  logic          oe,
  input  logic          sleep,
  input  op_e           s1_op,
  input  logic [AW-1:0] s1_addr,
  input  op_e           s2_op,
  input  logic [AW-1:0] s2_addr,
  input  logic [NB-1:0] s2_be,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          fwd_hit
);
  logic [DW-1:0] merged, out_q;
  logic          rd_live;

  // In registered mode the write committing at this edge is not yet in the array.
  assign fwd_hit = !ft_mode && (s2_op == OP_WR) && (s2_addr == s1_addr) && (s1_op == OP_RD);

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*BW +: BW] = (fwd_hit && s2_be[b]) ? din[b*BW +: BW]
                                                      : arr_rdata[b*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_q <= '0;
    else if (s1_op == OP_RD) out_q <= merged;
  end

  assign rd_live = ft_mode ? (s1_op == OP_RD) : (s2_op == OP_RD);
  assign dout    = ft_mode ? merged : out_q;
  assign dout_oe = rd_live && oe && !sleep;

endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTE  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTE * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ft_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              wr_en,
  input  logic [NBYTE-1:0]  byte_we,
  input  logic              ce1,
  input  logic              ce2,
  input  logic              ce3,
  input  logic              burst_lin,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, arr_waddr;
  logic [NBYTE-1:0]  s1_be, s2_be, arr_wbe;
  logic              load_go, cont_go, arr_we, fwd_hit, chip_sel;
  logic [DATA_W-1:0] arr_rdata;

  assign chip_sel = ce1 && ce2 && ce3;

  lwsram_cmd #(.AW(ADDR_W), .NB(NBYTE)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .adv_ld(adv_ld), .wr_en(wr_en),
    .sel(chip_sel), .burst_lin(burst_lin), .addr(addr), .byte_we(byte_we),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be),
    .load_go(load_go), .cont_go(cont_go)
  );

  // Late-write commit point: one stage in flow-through, two in registered mode.
  always_comb begin
    if (ft_mode) begin
      arr_we    = (s1_op == OP_WR);
      arr_waddr = s1_addr;
      arr_wbe   = s1_be;
    end else begin
      arr_we    = (s2_op == OP_WR);
      arr_waddr = s2_addr;
      arr_wbe   = s2_be;
    end
  end

  lwsram_array #(.AW(ADDR_W), .NB(NBYTE), .BW(BYTE_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wbe(arr_wbe), .wdata(din),
    .raddr(s1_addr), .rdata(arr_rdata)
  );

  lwsram_rdpath #(.AW(ADDR_W), .NB(NBYTE), .BW(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .oe(oe), .sleep(sleep),
    .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_be(s2_be), .din(din), .arr_rdata(arr_rdata),
    .dout(dout), .dout_oe(dout_oe), .fwd_hit(fwd_hit)
  );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
  import lwsram_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ft_mode,
  input logic          adv_ld,
  input logic          ce1,
  input logic          ce2,
  input logic          ce3,
  input logic          oe,
  input logic          sleep,
  input logic          dout_oe,
  input logic          arr_we,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr
);

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ld && !(ce1 && ce2 && ce3)) |=> (s1_op == OP_IDLE));

  p_reg_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_mode && s1_op == OP_RD) |=> (dout_oe == (oe && !sleep)));

  p_reg_late_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_mode && s1_op == OP_WR) |=> arr_we);

  p_burst_continue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld && !sleep && s1_op != OP_IDLE) |=>
      (s1_op == $past(s1_op) && s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dout_oe);

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_oe);

  p_sleep_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_op == OP_IDLE));

endmodule

bind lwsram lwsram_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .adv_ld(adv_ld),
  .ce1(ce1), .ce2(ce2), .ce3(ce3), .oe(oe), .sleep(sleep),
  .dout_oe(dout_oe), .arr_we(arr_we), .s1_op(s1_op), .s1_addr(s1_addr)
);

// File: tb/tb_lwsram.sv
module tb_lwsram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int NRAND = 1500;

  logic          clk = 0, rst_n = 0, ft_mode = 0, adv_ld = 0, wr_en = 0;
  logic          ce1 = 0, ce2 = 0, ce3 = 0, burst_lin = 1, oe = 1, sleep = 0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_we = '0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  wire           dout_oe;

  lwsram #(.ADDR_W(AW), .NBYTE(NB), .BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .addr(addr), .adv_ld(adv_ld),
    .wr_en(wr_en), .byte_we(byte_we), .ce1(ce1), .ce2(ce2), .ce3(ce3),
    .burst_lin(burst_lin), .oe(oe), .sleep(sleep), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R10";
  bit    done = 0, want_oe = 1, want_sleep = 0;

  // Reference state: only addresses 0..31 are used.
  logic [DW-1:0] ref_mem [32];
  bit            slot_rd [4];
  bit            slot_wr [4];
  logic [AW-1:0] slot_a  [4];
  logic [NB-1:0] slot_be [4];
  int            b_op = 0, b_beat = 0;
  logic [AW-1:0] b_base = '0;
  bit            b_lin = 1;

  function automatic logic [1:0] beat_ofs(logic [1:0] s, int n, bit lin);
    logic [1:0] nn;
    nn = n[1:0];
    if (lin) return 2'((int'(s) + n) % 4);
    return {s[1] ^ nn[1], s[0] ^ nn[0]};
  endfunction

  function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                               logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  task automatic fail_line(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h (edge %0d)", tag, what, act, exp, cyc);
  endtask

  task automatic check_out();
    int            s;
    bit            exp_oe;
    logic [DW-1:0] exp_d;
    s      = cyc % 4;
    exp_oe = slot_rd[s] && oe && !sleep;
    checks++;
    if (dout_oe !== exp_oe) fail_line("dout_oe", DW'(dout_oe), DW'(exp_oe));
    if (exp_oe) begin
      exp_d = ref_mem[slot_a[s][4:0]];
      checks++;
      if (dout !== exp_d) fail_line("read data", dout, exp_d);
    end
  endtask

  task automatic model_edge();
    int            s, op, t, lat;
    logic [AW-1:0] a;
    s   = cyc % 4;
    lat = ft_mode ? 1 : 2;
    if (slot_wr[s]) ref_mem[slot_a[s][4:0]] = lane_merge(ref_mem[slot_a[s][4:0]], din, slot_be[s]);
    slot_rd[s] = 0;
    slot_wr[s] = 0;
    op = 0;
    a  = addr;
    if (sleep) b_op = 0;
    else if (!adv_ld) begin
      if (ce1 && ce2 && ce3) begin
        op = wr_en ? 2 : 1;
        b_op = op; b_base = addr; b_beat = 0; b_lin = burst_lin;
      end else b_op = 0;
    end else if (b_op != 0) begin
      b_beat = (b_beat + 1) % 4;
      op = b_op;
      a = {b_base[AW-1:2], beat_ofs(b_base[1:0], b_beat, b_lin)};
    end
    if (op != 0) begin
      t = (cyc + lat) % 4;
      slot_rd[t] = (op == 1);
      slot_wr[t] = (op == 2);
      slot_a[t]  = a;
      slot_be[t] = byte_we;
    end
    cyc++;
  endtask

  task automatic tick(bit a, logic [2:0] ces, bit w, logic [AW-1:0] ad,
                      logic [NB-1:0] be, bit l);
    @(negedge clk);
    oe = want_oe;
    sleep = want_sleep;
    #1;
    check_out();
    adv_ld = a; ce1 = ces[0]; ce2 = ces[1]; ce3 = ces[2];
    wr_en = w; addr = ad; byte_we = be; burst_lin = l;
    din = DW'($urandom);
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 3'b000, 0, '0, '0, 1);
  endtask

  task automatic do_reset(bit ft);
    @(negedge clk);
    rst_n = 0; ft_mode = ft; adv_ld = 0; ce1 = 0; ce2 = 0; ce3 = 0;
    want_oe = 1; want_sleep = 0; oe = 1; sleep = 0;
    for (int i = 0; i < 4; i++) begin slot_rd[i] = 0; slot_wr[i] = 0; end
    b_op = 0; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R10";
    checks++;
    if (dout_oe !== 1'b0) fail_line("dout_oe after reset", DW'(dout_oe), '0);
    @(posedge clk);
    // The edge at reset release carries an idle load, as in the model.
    model_edge();
  endtask

  task automatic directed();
    tag = "R4";   // partial byte write then readback
    tick(0, 3'b111, 1, 8'd5, 2'b01, 1); idle(3);
    tick(0, 3'b111, 0, 8'd5, 2'b00, 1); idle(3);
    tick(0, 3'b111, 1, 8'd6, 2'b10, 1); idle(3);
    tick(0, 3'b111, 0, 8'd6, 2'b00, 1); idle(3);
    tag = "R7";   // write then immediate read of the same word
    tick(0, 3'b111, 1, 8'd9, 2'b10, 1);
    tick(0, 3'b111, 0, 8'd9, 2'b00, 1); idle(3);
    tick(0, 3'b111, 1, 8'd10, 2'b11, 1);
    tick(0, 3'b111, 0, 8'd10, 2'b00, 1);
    tick(0, 3'b111, 0, 8'd10, 2'b00, 1); idle(3);
    tag = "R5";   // alternating reads and writes, no gaps
    tick(0, 3'b111, 1, 8'd12, 2'b11, 1);
    tick(0, 3'b111, 0, 8'd13, 2'b00, 1);
    tick(0, 3'b111, 1, 8'd13, 2'b11, 1);
    tick(0, 3'b111, 0, 8'd12, 2'b00, 1);
    tick(0, 3'b111, 1, 8'd12, 2'b01, 1);
    tick(0, 3'b111, 0, 8'd13, 2'b00, 1);
    tick(0, 3'b111, 0, 8'd12, 2'b00, 1); idle(3);
    tag = "R6";   // start offset 1: linear 1,2,3,0 vs interleaved 1,0,3,2, with wrap
    tick(0, 3'b111, 0, 8'd17, 2'b00, 1);
    for (int i = 0; i < 5; i++) tick(1, 3'b000, 1, 8'd0, 2'b00, 0);
    tick(0, 3'b111, 0, 8'd17, 2'b00, 0);
    for (int i = 0; i < 4; i++) tick(1, 3'b000, 0, 8'd0, 2'b00, 1);
    tick(0, 3'b111, 1, 8'd22, 2'b11, 0);
    for (int i = 0; i < 3; i++) tick(1, 3'b000, 0, 8'd0, 2'b11, 1);
    tick(0, 3'b111, 0, 8'd20, 2'b00, 1);
    for (int i = 0; i < 3; i++) tick(1, 3'b000, 0, 8'd0, 2'b00, 1);
    tick(0, 3'b011, 0, 8'd20, 2'b00, 1);   // deselect, then advance stays idle
    tick(1, 3'b111, 0, 8'd0, 2'b00, 1); idle(3);
    tag = "R1";   // one chip enable low: write must not land
    tick(0, 3'b110, 1, 8'd25, 2'b11, 1);
    tick(0, 3'b101, 1, 8'd25, 2'b11, 1);
    tick(0, 3'b011, 1, 8'd25, 2'b11, 1); idle(3);
    tick(0, 3'b111, 0, 8'd25, 2'b00, 1); idle(3);
    tag = "R8";   // output enable low while reads are due
    tick(0, 3'b111, 0, 8'd3, 2'b00, 1);
    for (int i = 0; i < 3; i++) tick(1, 3'b000, 0, 8'd0, 2'b00, 1);
    want_oe = 0; idle(1); tick(0, 3'b111, 0, 8'd4, 2'b00, 1); idle(2);
    want_oe = 1; idle(2);
    tag = "R9";   // writes during sleep ignored, contents kept
    tick(0, 3'b111, 0, 8'd30, 2'b00, 1);
    want_sleep = 1;
    tick(0, 3'b111, 1, 8'd30, 2'b11, 1);
    tick(0, 3'b111, 1, 8'd31, 2'b11, 1);
    tick(1, 3'b111, 1, 8'd31, 2'b11, 1); idle(2);
    want_sleep = 0; idle(2);
    tick(0, 3'b111, 0, 8'd30, 2'b00, 1);
    tick(0, 3'b111, 0, 8'd31, 2'b00, 1); idle(3);
  endtask

  task automatic random_mix(string t);
    tag = t;
    for (int i = 0; i < NRAND; i++) begin
      bit         a;
      logic [2:0] ces;
      a   = ($urandom % 10) < 4;
      ces = ($urandom % 8 == 0) ? 3'($urandom) : 3'b111;
      want_oe    = ($urandom % 10) != 0;
      want_sleep = ($urandom % 40) == 0;
      tick(a, ces, 1'($urandom), AW'($urandom % 32), NB'($urandom), 1'($urandom));
    end
    want_oe = 1; want_sleep = 0;
    idle(4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) ref_mem[i] = '0;
    do_reset(0);
    tag = "R2";   // fill with linear write bursts
    for (int g = 0; g < 8; g++) begin
      tick(0, 3'b111, 1, AW'(4 * g), 2'b11, 1);
      for (int i = 0; i < 3; i++) tick(1, 3'b000, 0, '0, 2'b11, 1);
    end
    idle(3);
    directed();
    random_mix("R2");
    idle(4);
    do_reset(1);
    directed();
    random_mix("R3");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, tag %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule